// File: doc/BRIEF.md
# String-to-Port Output Sequencer

This block moves a run of elements from memory to a single I/O port. One start pulse hands it a segment base, a source index, a 16-bit port number, an opcode with an operand-size bit that together pick the element width, a direction bit, an address-width bit, a repeat enable and an element count. For each element it issues a memory read, captures the returned data, waits until all earlier memory stores have drained, then presents a write on the I/O bus and holds until the port acknowledges. Only after that acknowledge does it step the index and the count and move on.

The memory and I/O sides use valid/ready request handshakes. The memory answers with a one-cycle response strobe and the port with a one-cycle acknowledge. When the run ends the block raises a one-cycle completion pulse and presents the updated index and count. These stay visible until the next start.

Top module: `string_out_seq`

## Requirements
- R1: While reset is high and after its release, `busy`, `done`, `mem_rd_valid` and `io_wr_valid` are low, and `final_index` and `final_count` read zero.
- R2: Opcode 0x6E selects byte elements. Opcode 0x6F selects 32-bit elements when `operand32` is 1 and 16-bit elements otherwise. A start with any other opcode is ignored: no request appears and `busy` stays low.
- R3: The read address is `seg_base` plus the index. In 16-bit address mode (`addr32`=0) only the low 16 bits of the index take part.
- R4: After each acknowledged element the index moves by the element size (1, 2 or 4). It moves up when `dir_flag` is 0 and down when it is 1.
- R5: In 16-bit address mode the index update wraps modulo 65,536 and the upper index bits are kept. In 32-bit mode it wraps modulo 2^32.
- R6: With `rep_en`=1 and a nonzero count, exactly that many elements are transferred. The count drops by one per acknowledged element and ends at zero.
- R7: With `rep_en`=0, exactly one element is transferred and the count is returned unchanged.
- R8: With `rep_en`=1 and a count of zero, no read or port write occurs. `done` rises in the cycle after the start, with the index unchanged.
- R9: A port write starts only after `store_drained` was high. No memory read is requested between a port write and its acknowledge.
- R10: The port bus carries the port number and the element in its low bytes, with upper bytes zero. The byte enables are 0x1, 0x3 or 0xF for byte, 16-bit and 32-bit elements, and `mem_be` carries the same code.
- R11: `done` is a one-cycle pulse in the cycle after the last acknowledge. In that cycle `final_index` and `final_count` hold the updated values.
- R12: A read or write request held without ready stays valid, with its address, port and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle |
| opcode | input | 8 | 0x6E byte, 0x6F wide element |
| operand32 | input | 1 | Wide element is 32-bit when 1, 16-bit when 0 |
| seg_base | input | 32 | Segment base added to the index |
| src_index | input | 32 | Initial source index |
| port_num | input | 16 | Target I/O port |
| dir_flag | input | 1 | 0 step up, 1 step down |
| addr32 | input | 1 | 1: 32-bit index, 0: 16-bit index |
| rep_en | input | 1 | Repeat by count |
| count_in | input | 32 | Element count for repeat |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts request |
| mem_addr | output | 32 | Read address |
| mem_be | output | 4 | Bytes wanted by the read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data, element in low bytes |
| store_drained | input | 1 | Earlier memory stores complete |
| io_wr_valid | output | 1 | Port write request |
| io_wr_ready | input | 1 | Port accepts write |
| io_port | output | 16 | Port number |
| io_data | output | 32 | Element, low-byte aligned |
| io_be | output | 4 | Byte enables for element size |
| io_ack | input | 1 | Port write acknowledge |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| final_index | output | 32 | Index after the run |
| final_count | output | 32 | Count after the run |

## Verification
The assertions check these on every clock: the count stepping down by one (or holding) on each acknowledge, the upper index bits surviving 16-bit updates, the drain precondition on each new port write, the immediate completion of zero-count runs, the single-cycle `done`, byte-enable shape and request stability under backpressure. The bench's reference model covers what only whole scenarios show. This includes the exact addresses in both directions and modes, the wrap across 0xFFFF and 2^32, the masked port data, the final index and count of each run, the absence of reads while a write awaits its acknowledge, a long drain stall, and the rejection of an unknown opcode.

// File: rtl/sos_pkg.sv
package sos_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } elem_size_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_PUT   = 3'd4,
    ST_ACK   = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_e;

  localparam logic [7:0] OP_NARROW = 8'h6E;
  localparam logic [7:0] OP_WIDE   = 8'h6F;

  function automatic logic [2:0] elem_bytes(elem_size_e s);
    case (s)
      SZ_BYTE: elem_bytes = 3'd1;
      SZ_WORD: elem_bytes = 3'd2;
      default: elem_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sos_step_unit.sv
module sos_step_unit
  import sos_pkg::*;
#(
  parameter int IDX_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic [IDX_W-1:0]  idx,
  input  elem_size_e        size,
  input  logic              dir_down,
  input  logic              wide_addr,
  input  logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  next_idx,
  output logic [ADDR_W-1:0] src_addr
);

  localparam int HI_W = IDX_W - SHORT_W;

  logic [IDX_W-1:0] step;
  logic [IDX_W-1:0] moved;
  logic [IDX_W-1:0] eff_idx;

  always_comb begin
    step  = {{(IDX_W-3){1'b0}}, elem_bytes(size)};
    moved = dir_down ? (idx - step) : (idx + step);
    if (wide_addr) begin
      next_idx = moved;
      eff_idx  = idx;
    end else begin
      next_idx = {idx[IDX_W-1:SHORT_W], moved[SHORT_W-1:0]};
      eff_idx  = {{HI_W{1'b0}}, idx[SHORT_W-1:0]};
    end
    src_addr = base + ADDR_W'(eff_idx);
  end

endmodule

// File: rtl/sos_lane_fmt.sv
module sos_lane_fmt
  import sos_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   raw,
  input  elem_size_e          size,
  output logic [DATA_W-1:0]   data,
  output logic [DATA_W/8-1:0] be
);

  localparam int LANES = DATA_W / 8;

  logic [7:0] n_bytes;
  assign n_bytes = {5'b0, elem_bytes(size)};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [7:0] LANE_ID = 8'(g);
    assign be[g]           = (n_bytes > LANE_ID);
    assign data[g*8 +: 8]  = be[g] ? raw[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/sos_ctrl.sv
module sos_ctrl
  import sos_pkg::*;
#(
  parameter int IDX_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int PORT_W  = 16,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              operand32,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [IDX_W-1:0]  src_index,
  input  logic [PORT_W-1:0] port_num,
  input  logic              dir_flag,
  input  logic              addr32,
  input  logic              rep_en,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              mem_rd_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              store_drained,
  input  logic              io_wr_ready,
  input  logic              io_ack,
  input  logic [IDX_W-1:0]  next_idx,
  output logic [IDX_W-1:0]  idx_q,
  output logic [ADDR_W-1:0] base_q,
  output elem_size_e        size_q,
  output logic              dir_q,
  output logic              a32_q,
  output logic [PORT_W-1:0] port_q,
  output logic [DATA_W-1:0] data_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              mem_rd_valid,
  output logic              io_wr_valid,
  output logic              busy,
  output logic              done
);

  seq_state_e state;
  logic       rep_q;
  logic       start_ok;
  logic       last_elem;

  assign start_ok  = start && (opcode == OP_NARROW || opcode == OP_WIDE);
  assign last_elem = !rep_q || (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      size_q <= SZ_BYTE;
      dir_q  <= 1'b0;
      a32_q  <= 1'b0;
      rep_q  <= 1'b0;
      port_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            idx_q  <= src_index;
            base_q <= seg_base;
            dir_q  <= dir_flag;
            a32_q  <= addr32;
            rep_q  <= rep_en;
            port_q <= port_num;
            cnt_q  <= count_in;
            if (opcode == OP_NARROW) size_q <= SZ_BYTE;
            else if (operand32)      size_q <= SZ_DWORD;
            else                     size_q <= SZ_WORD;
            state <= (rep_en && count_in == '0) ? ST_DONE : ST_FETCH;
          end
        end
        ST_FETCH: if (mem_rd_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            state  <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (store_drained) state <= ST_PUT;
        ST_PUT:   if (io_wr_ready)   state <= ST_ACK;
        ST_ACK: begin
          if (io_ack) begin
            idx_q <= next_idx;
            if (rep_q) cnt_q <= cnt_q - CNT_W'(1);
            state <= last_elem ? ST_DONE : ST_FETCH;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_valid = (state == ST_FETCH);
  assign io_wr_valid  = (state == ST_PUT);
  assign done         = (state == ST_DONE);
  assign busy         = (state != ST_IDLE) && (state != ST_DONE);

  assert_read_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(idx_q) && $stable(base_q)));

  assert_write_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (io_wr_valid && !io_wr_ready) |=> (io_wr_valid && $stable(data_q) && $stable(port_q)));

  assert_drain_first_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(io_wr_valid) |-> $past(store_drained));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && io_ack && rep_q) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_single_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && io_ack && !rep_q) |=> (done && cnt_q == $past(cnt_q)));

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start_ok && rep_en && count_in == '0) |=> (done && !mem_rd_valid));

  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && io_ack && !a32_q) |=>
      (idx_q[IDX_W-1:SHORT_W] == $past(idx_q[IDX_W-1:SHORT_W])));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/string_out_seq.sv
module string_out_seq
  import sos_pkg::*;
#(
  parameter int IDX_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int PORT_W  = 16,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int SHORT_W = 16,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              operand32,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [IDX_W-1:0]  src_index,
  input  logic [PORT_W-1:0] port_num,
  input  logic              dir_flag,
  input  logic              addr32,
  input  logic              rep_en,
  input  logic [CNT_W-1:0]  count_in,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              store_drained,
  output logic              io_wr_valid,
  input  logic              io_wr_ready,
  output logic [PORT_W-1:0] io_port,
  output logic [DATA_W-1:0] io_data,
  output logic [LANES-1:0]  io_be,
  input  logic              io_ack,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  final_index,
  output logic [CNT_W-1:0]  final_count
);

  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  next_idx;
  logic [ADDR_W-1:0] base_q;
  elem_size_e        size_q;
  logic              dir_q;
  logic              a32_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;

  sos_ctrl #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W),
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SHORT_W(SHORT_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .operand32(operand32),
    .seg_base(seg_base), .src_index(src_index), .port_num(port_num),
    .dir_flag(dir_flag), .addr32(addr32), .rep_en(rep_en), .count_in(count_in),
    .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .store_drained(store_drained),
    .io_wr_ready(io_wr_ready), .io_ack(io_ack), .next_idx(next_idx),
    .idx_q(idx_q), .base_q(base_q), .size_q(size_q), .dir_q(dir_q),
    .a32_q(a32_q), .port_q(io_port), .data_q(data_q), .cnt_q(cnt_q),
    .mem_rd_valid(mem_rd_valid), .io_wr_valid(io_wr_valid),
    .busy(busy), .done(done)
  );

  sos_step_unit #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) i_step (
    .idx(idx_q), .size(size_q), .dir_down(dir_q), .wide_addr(a32_q),
    .base(base_q), .next_idx(next_idx), .src_addr(mem_addr)
  );

  sos_lane_fmt #(.DATA_W(DATA_W)) i_lane (
    .raw(data_q), .size(size_q), .data(io_data), .be(io_be)
  );

  assign mem_be      = io_be;
  assign final_index = idx_q;
  assign final_count = cnt_q;

  assert_be_shape_R10: assert property (@(posedge clk) disable iff (rst)
    io_wr_valid |-> (io_be[0] &&
      ($countones(io_be) == 1 || $countones(io_be) == 2 || $countones(io_be) == 4)));

endmodule

// File: tb/test_string_out_seq.sv
`timescale 1ns/1ps
module test_string_out_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        operand32 = 1'b0;
  logic [31:0] seg_base = '0;
  logic [31:0] src_index = '0;
  logic [15:0] port_num = '0;
  logic        dir_flag = 1'b0;
  logic        addr32 = 1'b0;
  logic        rep_en = 1'b0;
  logic [31:0] count_in = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        store_drained = 1'b1;
  logic        io_wr_valid;
  logic        io_wr_ready = 1'b0;
  logic [15:0] io_port;
  logic [31:0] io_data;
  logic [3:0]  io_be;
  logic        io_ack = 1'b0;
  logic        busy;
  logic        done;
  logic [31:0] final_index;
  logic [31:0] final_count;

  always #2 clk = ~clk;

  string_out_seq i_string_out_seq (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .operand32(operand32),
    .seg_base(seg_base), .src_index(src_index), .port_num(port_num),
    .dir_flag(dir_flag), .addr32(addr32), .rep_en(rep_en), .count_in(count_in),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .store_drained(store_drained), .io_wr_valid(io_wr_valid),
    .io_wr_ready(io_wr_ready), .io_port(io_port), .io_data(io_data),
    .io_be(io_be), .io_ack(io_ack), .busy(busy), .done(done),
    .final_index(final_index), .final_count(final_count)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // command handed from the scenario thread to the cycle loop
  bit          go = 0, seen_done = 0, run = 0, drain_hold = 0;
  logic [7:0]  c_op;
  bit          c_o32, c_dir, c_a32, c_rep;
  logic [31:0] c_base, c_idx, c_cnt;
  logic [15:0] c_port;

  // reference model state
  bit          active = 0, exp_done_next = 0, mem_out = 0, io_pend = 0;
  bit          prev_mem_wait = 0, prev_io_wait = 0, prev_io_v = 0;
  bit          m_dir, m_a32, m_rep;
  int          m_n = 1;
  int          rsp_dly = 0, ack_dly = 0;
  logic [31:0] m_idx = '0, m_cnt = '0, m_base = '0, m_data = '0, pend_raw = '0;
  logic [31:0] prev_addr = '0, prev_data = '0;
  logic [15:0] m_port = '0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] eff(input logic [31:0] i, input bit a32);
    return a32 ? i : {16'h0, i[15:0]};
  endfunction
  function automatic logic [31:0] nxt(input logic [31:0] i, input bit a32,
                                     input bit dn, input int n);
    logic [31:0] w;
    logic [15:0] s;
    w = dn ? i - 32'(n) : i + 32'(n);
    s = dn ? i[15:0] - 16'(n) : i[15:0] + 16'(n);
    return a32 ? w : {i[31:16], s};
  endfunction
  function automatic logic [31:0] lane_mask(input int n);
    return (n == 1) ? 32'h0000_00FF : (n == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [3:0] be_of(input int n);
    return (n == 1) ? 4'h1 : (n == 2) ? 4'h3 : 4'hF;
  endfunction

  // cycle loop: reference model, responders and comparisons at each falling edge
  initial begin
    bit exp_done_now;
    wait (run);
    forever begin
      @(negedge clk);
      exp_done_now  = exp_done_next;
      exp_done_next = 0;

      chk(done == exp_done_now, "R11 done pulse", 32'(done), 32'(exp_done_now));
      if (done) begin
        chk(final_index == m_idx, "R4 R5 final index", final_index, m_idx);
        chk(final_count == m_cnt, "R6 R7 final count", final_count, m_cnt);
        seen_done = 1;
      end
      if (mem_rd_valid) begin
        chk(active && !io_pend && !mem_out, "R9 R8 read gating", 32'(mem_rd_valid), 0);
        chk(mem_addr == m_base + eff(m_idx, m_a32), "R3 read address",
            mem_addr, m_base + eff(m_idx, m_a32));
        chk(mem_be == be_of(m_n), "R2 R10 read size", 32'(mem_be), 32'(be_of(m_n)));
      end
      if (prev_mem_wait)
        chk(mem_rd_valid && mem_addr == prev_addr, "R12 read held", mem_addr, prev_addr);
      if (io_wr_valid && !prev_io_v)
        chk(store_drained, "R9 drain before write", 32'(store_drained), 1);
      if (io_wr_valid) begin
        chk(active, "R9 write gating", 32'(io_wr_valid), 0);
        chk(io_port == m_port, "R10 port", 32'(io_port), 32'(m_port));
        chk(io_data == m_data, "R10 port data", io_data, m_data);
        chk(io_be == be_of(m_n), "R10 byte enables", 32'(io_be), 32'(be_of(m_n)));
      end
      if (prev_io_wait)
        chk(io_wr_valid && io_data == prev_data, "R12 write held", io_data, prev_data);

      // memory responder
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = $urandom;
      if (mem_out) begin
        if (rsp_dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend_raw;
          m_data        = pend_raw & lane_mask(m_n);
          mem_out       = 0;
        end else rsp_dly--;
      end
      mem_rd_ready  = ($urandom % 4) != 0;
      prev_mem_wait = mem_rd_valid && !mem_rd_ready;
      prev_addr     = mem_addr;
      if (mem_rd_valid && mem_rd_ready) begin
        mem_out  = 1;
        rsp_dly  = $urandom % 3;
        pend_raw = memf(mem_addr);
      end

      // port responder and model step on acknowledge
      io_ack = 1'b0;
      if (io_pend) begin
        if (ack_dly == 0) begin
          io_ack  = 1'b1;
          io_pend = 0;
          m_idx   = nxt(m_idx, m_a32, m_dir, m_n);
          if (m_rep) m_cnt = m_cnt - 1;
          if (!m_rep || m_cnt == 0) begin
            active        = 0;
            exp_done_next = 1;
          end
        end else ack_dly--;
      end
      io_wr_ready  = ($urandom % 3) != 0;
      prev_io_wait = io_wr_valid && !io_wr_ready;
      prev_data    = io_data;
      prev_io_v    = io_wr_valid;
      if (io_wr_valid && io_wr_ready) begin
        io_pend = 1;
        ack_dly = $urandom % 4;
      end

      store_drained = drain_hold ? 1'b0 : (($urandom % 4) != 0);

      // command issue
      start = 1'b0;
      if (go) begin
        go        = 0;
        start     = 1'b1;
        opcode    = c_op;   operand32 = c_o32; seg_base = c_base;
        src_index = c_idx;  port_num  = c_port; dir_flag = c_dir;
        addr32    = c_a32;  rep_en    = c_rep;  count_in = c_cnt;
        if (c_op == 8'h6E || c_op == 8'h6F) begin
          m_n    = (c_op == 8'h6E) ? 1 : (c_o32 ? 4 : 2);
          m_idx  = c_idx;  m_cnt = c_cnt; m_base = c_base; m_port = c_port;
          m_dir  = c_dir;  m_a32 = c_a32; m_rep  = c_rep;
          if (c_rep && c_cnt == 0) exp_done_next = 1;
          else active = 1;
        end
      end
    end
  end

  task automatic issue(input logic [7:0] op, input bit o32, input logic [31:0] base,
                       input logic [31:0] idx, input logic [15:0] port, input bit dn,
                       input bit a32, input bit rep, input logic [31:0] cnt);
    c_op = op; c_o32 = o32; c_base = base; c_idx = idx; c_port = port;
    c_dir = dn; c_a32 = a32; c_rep = rep; c_cnt = cnt;
    seen_done = 0;
    go = 1;
  endtask

  task automatic finish_run();
    wait (seen_done);
    seen_done = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done, "R1 reset status", {30'b0, busy, done}, 0);
    chk(!mem_rd_valid && !io_wr_valid, "R1 reset requests",
        {30'b0, mem_rd_valid, io_wr_valid}, 0);
    chk(final_index == 0 && final_count == 0, "R1 reset finals", final_index, 0);
    rst = 1'b0;
    run = 1;
    @(negedge clk);
    chk(!busy && !done, "R1 after release", {30'b0, busy, done}, 0);

    // R2 R4 R6: byte elements, upward, 32-bit index, repeat 5
    issue(8'h6E, 0, 32'h0001_0000, 32'h0000_1000, 16'h03F8, 0, 1, 1, 32'd5);
    finish_run();
    // R5 R6: 16-bit elements, downward, 16-bit index wrapping below zero
    issue(8'h6F, 0, 32'h0002_0000, 32'hABCD_0002, 16'hFFFF, 1, 0, 1, 32'd3);
    finish_run();
    // R5: 32-bit elements, upward, 32-bit index wrapping past 2^32
    issue(8'h6F, 1, 32'h0000_0100, 32'hFFFF_FFF8, 16'h0000, 0, 1, 1, 32'd4);
    finish_run();
    // R5: 32-bit elements, 16-bit index wrapping upward, upper bits kept
    issue(8'h6F, 1, 32'h1000_0000, 32'h7777_FFFC, 16'h1234, 0, 0, 1, 32'd3);
    finish_run();
    // R7: no repeat, count must come back unchanged
    issue(8'h6F, 0, 32'h0000_0040, 32'h0000_0010, 16'h0060, 1, 1, 0, 32'd7);
    finish_run();
    // R8: repeat with zero count
    issue(8'h6E, 0, 32'h0000_0000, 32'h0000_0123, 16'h0080, 0, 1, 1, 32'd0);
    finish_run();
    // R2: unknown opcode ignored
    issue(8'h90, 0, 32'h0, 32'h0000_0200, 16'h0070, 0, 1, 1, 32'd2);
    repeat (10) @(negedge clk);
    chk(!busy && !seen_done, "R2 unknown opcode ignored", {31'b0, busy}, 0);
    // R9: drain held low, no port write may appear
    drain_hold = 1;
    issue(8'h6F, 1, 32'h0000_8000, 32'h0000_0020, 16'h00C0, 0, 1, 1, 32'd2);
    repeat (30) @(negedge clk);
    chk(!io_wr_valid && busy, "R9 stalled by drain", {31'b0, io_wr_valid}, 0);
    drain_hold = 0;
    finish_run();
    // R4: byte elements, downward, long repeat
    issue(8'h6E, 0, 32'h0000_0000, 32'h0000_0040, 16'h0021, 1, 1, 1, 32'd20);
    finish_run();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule